// File: doc/BRIEF.md
# Retentive Accumulating Timer

This block measures how long an enable input has been high. The time may be split over any number of separate enable periods. A free-running strobe marks 100 ms ticks. On each tick that arrives while enable is high, the block adds one to a running count. When enable drops, the count is not thrown away: it stays where it was, and the next enable period carries on from that value.

The done output is true when the running count equals the preset and enable is high at that moment. It is not a latched flag. Taking enable low drops done at once, even though the count stays at the preset.

The count never moves past the preset. The only way to return it to zero is the synchronous clear input, or the asynchronous reset. Tick generation happens outside this block.

Top module: `ret_acc_timer`

## Requirements
- R1: On a rising clock edge where `tick_i`=1, `en_i`=1, `clr_i`=0 and `acc_o` < `preset_i`, `acc_o` increases by exactly one. `preset_i` is counted in ticks.
- R2: While `en_i`=0 and `clr_i`=0, `acc_o` keeps its value whatever `tick_i` does.
- R3: When `en_i` goes high again after a pause, counting continues from the held value, not from zero.
- R4: `clr_i`=1 sets `acc_o` to 0 at the next rising edge. It takes priority over every other input.
- R5: `done_o` is combinational. It equals `en_i` AND (`acc_o` == `preset_i`).
- R6: Once `acc_o` equals `preset_i`, further ticks leave `acc_o` unchanged.
- R7: With `preset_i`=0, `acc_o` stays 0 and `done_o` follows `en_i`.
- R8: If `preset_i` is lowered below the current `acc_o`, `acc_o` holds and `done_o` stays 0, because the terminal test is an equality.
- R9: `rst_ni`=0 clears `acc_o` to 0 asynchronously.
- R10: With `tick_i`=0, `acc_o` does not advance even while `en_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle 100 ms time-base strobe |
| en_i | input | 1 | Timing enable |
| clr_i | input | 1 | Synchronous clear of the accumulated time |
| preset_i | input | CNT_W | Terminal count, in ticks |
| acc_o | output | CNT_W | Accumulated tick count |
| done_o | output | 1 | Terminal reached and enable high |

## Verification
The bench pauses enable partway through a count and then resumes it. A design that restarts from zero would miss the expected value.

It keeps ticking after the preset has been reached, to catch a counter that runs past the preset and wraps. It lowers enable at the terminal count, to catch a done output that has been latched instead of gated.

It also covers three edge cases. A preset lowered below the held count would expose a magnitude compare in place of equality. A preset of zero would expose an off-by-one in the terminal test. A clear asserted together with a tick would expose clear losing its priority.

// File: rtl/rat_pkg.sv
package rat_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_STEP  = 2'd1,
    ACT_CLEAR = 2'd2
  } acc_act_e;
endpackage

// File: rtl/rat_term_cmp.sv
module rat_term_cmp #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] acc_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic             at_preset_o,
  output logic             below_o
);
  assign at_preset_o = (acc_i == preset_i);
  assign below_o     = (acc_i < preset_i);
endmodule

// File: rtl/rat_ctrl.sv
module rat_ctrl
  import rat_pkg::*;
(
  input  logic     clr_i,
  input  logic     en_i,
  input  logic     tick_i,
  input  logic     below_i,
  output acc_act_e act_o
);
  always_comb begin
    if (clr_i)                          act_o = ACT_CLEAR;
    else if (en_i && tick_i && below_i) act_o = ACT_STEP;
    else                                act_o = ACT_HOLD;
  end
endmodule

// File: rtl/rat_accum.sv
module rat_accum
  import rat_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  acc_act_e         act_i,
  output logic [CNT_W-1:0] acc_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else begin
      unique case (act_i)
        ACT_CLEAR: acc_q <= '0;
        ACT_STEP:  acc_q <= acc_q + ONE;
        default:   acc_q <= acc_q;
      endcase
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/ret_acc_timer.sv
module ret_acc_timer
  import rat_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic [CNT_W-1:0] acc_o,
  output logic             done_o
);
  logic     at_preset;
  logic     below;
  acc_act_e act;

  rat_term_cmp #(.CNT_W(CNT_W)) u_cmp (
    .acc_i       (acc_o),
    .preset_i    (preset_i),
    .at_preset_o (at_preset),
    .below_o     (below)
  );

  rat_ctrl u_ctrl (
    .clr_i   (clr_i),
    .en_i    (en_i),
    .tick_i  (tick_i),
    .below_i (below),
    .act_o   (act)
  );

  rat_accum #(.CNT_W(CNT_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .act_i  (act),
    .acc_o  (acc_o)
  );

  // live gate: done drops with enable, count is retained
  assign done_o = en_i & at_preset;
endmodule

// File: rtl/rat_checker.sv
module rat_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             en_i,
  input logic             clr_i,
  input logic [CNT_W-1:0] preset_i,
  input logic [CNT_W-1:0] acc_o,
  input logic             done_o
);
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i && tick_i && acc_o < preset_i) |=> acc_o == $past(acc_o) + CNT_W'(1)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(acc_o)); // R2
  AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !tick_i) |=> $stable(acc_o)); // R10
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_o == '0); // R4
  AST_NO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && acc_o >= preset_i) |=> $stable(acc_o)); // R6
  AST_DONE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (en_i && acc_o == preset_i)); // R5
  AST_DONE_BELOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_o > preset_i) |-> !done_o); // R8
endmodule

bind ret_acc_timer rat_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/ret_acc_timer_tb.sv
module ret_acc_timer_tb;
  localparam int W  = 8;
  localparam int NV = 15;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tick_i = 1'b0;
  logic         en_i = 1'b0;
  logic         clr_i = 1'b0;
  logic [W-1:0] preset_i = '0;
  logic [W-1:0] acc_o;
  logic         done_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk_i = ~clk_i;

  ret_acc_timer #(.CNT_W(W)) u_dut (.*);

  // {clr, en, tick, preset[8], acc after edge[8], done before edge, req[4]}
  localparam logic [23:0] VEC [NV] = '{
    {1'b0,1'b1,1'b1,8'd4,8'd1,1'b0,4'd1},   // R1
    {1'b0,1'b1,1'b0,8'd4,8'd1,1'b0,4'd10},  // R10
    {1'b0,1'b1,1'b1,8'd4,8'd2,1'b0,4'd1},   // R1
    {1'b0,1'b0,1'b1,8'd4,8'd2,1'b0,4'd2},   // R2
    {1'b0,1'b0,1'b1,8'd4,8'd2,1'b0,4'd2},   // R2
    {1'b0,1'b1,1'b1,8'd4,8'd3,1'b0,4'd3},   // R3
    {1'b0,1'b1,1'b1,8'd4,8'd4,1'b0,4'd1},   // R1
    {1'b0,1'b1,1'b1,8'd4,8'd4,1'b1,4'd6},   // R6
    {1'b0,1'b0,1'b1,8'd4,8'd4,1'b0,4'd5},   // R5
    {1'b0,1'b1,1'b0,8'd4,8'd4,1'b1,4'd5},   // R5
    {1'b0,1'b1,1'b1,8'd2,8'd4,1'b0,4'd8},   // R8
    {1'b1,1'b1,1'b1,8'd4,8'd0,1'b1,4'd4},   // R4
    {1'b0,1'b0,1'b0,8'd0,8'd0,1'b0,4'd7},   // R7
    {1'b0,1'b1,1'b1,8'd0,8'd0,1'b1,4'd7},   // R7
    {1'b1,1'b1,1'b1,8'd0,8'd0,1'b1,4'd4}    // R4
  };

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #200_000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    check(acc_o, 0, "R9 reset acc");
    check({7'd0, done_o}, 0, "R9 reset done");
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      automatic logic [23:0] v = VEC[i];
      automatic string rq = $sformatf("R%0d vec%0d", v[3:0], i);
      clr_i = v[23]; en_i = v[22]; tick_i = v[21]; preset_i = v[20:13];
      #1;
      check({7'd0, done_o}, {7'd0, v[4]}, rq);
      @(negedge clk_i);
      check(acc_o, v[12:5], rq);
    end

    // R1 R6: long count to preset 20, then saturate
    clr_i = 1'b0; en_i = 1'b1; tick_i = 1'b1; preset_i = 8'd20;
    repeat (25) @(negedge clk_i);
    check(acc_o, 20, "R6 saturate");
    check({7'd0, done_o}, 1, "R5 done at preset");

    // R9: async reset mid count
    clr_i = 1'b1; @(negedge clk_i); clr_i = 1'b0;
    repeat (5) @(negedge clk_i);
    check(acc_o, 5, "R1 count five");
    #1 rst_ni = 1'b0;
    #1 check(acc_o, 0, "R9 async clear");
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R3: sparse ticks across two enable windows
    tick_i = 1'b0;
    for (int k = 0; k < 6; k++) begin
      en_i = (k != 2 && k != 3);
      tick_i = 1'b1; @(negedge clk_i);
      tick_i = 1'b0; @(negedge clk_i);
    end
    check(acc_o, 4, "R3 resume across windows");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule